// File: doc/BRIEF.md
# Annealing Flip-Pulse Scheduler

This block produces two independent random pulse streams for a stochastic spin-update array. On each clock cycle of an active run, each stream is high when its own pseudo-random word is strictly below the current flip probability (the mark rate). The mark rate is held as an unsigned fraction of full scale. Over a programmed number of schedule steps it falls from a programmed starting value to a programmed ending value. After that it is forced to zero for a fixed settling period, so the array can relax into a stable state. Downstream logic ANDs the two streams to form the per-spin flip condition.

The fast clock runs at a fixed multiple (default 3) of the step rate, so each schedule step yields three pulse values per stream. A run is launched with a one-cycle start request while the block is idle. The block then takes a short setup period to work out the per-step decrement. It shows busy for the whole run and raises done for one cycle when the settling period ends.

Top module: `flip_pulse_sched`

## Requirements
- R1: After reset, and whenever reset is asserted, busy, done, pulse_a and pulse_b are all 0.
- R2: A start request sampled while idle launches a run, with busy high from the next cycle. start, steps_n, rate_init and rate_final are sampled only on that edge. A start request while busy is ignored.
- R3: Each stream uses a 16-bit Galois shift register that shifts right. When bit 0 is 1, the shifted word is XORed with 0xB400. Stream A is seeded with 0xACE1 and stream B with 0x1D2B at every accepted start. Each register advances once per cycle during the schedule and the settling period, and holds otherwise.
- R4: A pulse output is the registered result of (random word < mark rate), using unsigned strict comparison on the word before that cycle's advance.
- R5: The first compare result appears on the 17th rising edge after the start edge (setup = rate width). Compare results then follow on consecutive edges.
- R6: The schedule has steps_n+1 steps of 3 cycles each. During step k the mark rate is rate_init − floor(k·(rate_init − rate_final)/steps_n), so step steps_n runs at exactly rate_final.
- R7: If rate_final ≥ rate_init, the mark rate stays at rate_init for every step.
- R8: If steps_n = 0, the schedule is one step at min(rate_init, rate_final).
- R9: After the schedule, 1000 steps (3000 cycles) follow at mark rate zero, with both pulses low. Pulses are also low whenever idle.
- R10: done is high for exactly one cycle, on the cycle after the last settling cycle, and busy is already low in that cycle. A start request in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (3 cycles per schedule step) |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle run request |
| steps_n | input | 16 | Number of schedule steps to reach the final rate |
| rate_init | input | 16 | Starting mark rate, fraction of 65536 |
| rate_final | input | 16 | Ending mark rate, fraction of 65536 |
| pulse_a | output | 1 | Random pulse stream A |
| pulse_b | output | 1 | Random pulse stream B |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
The schedule is tried with several rate pairs: a normal descending pair near 0.75 and 0.01 of full scale, a full-scale-to-zero drop over one step, a rising pair that must stay flat, a zero step count, an all-zero pair that never pulses, and an equal pair. Comparing every pulse of both streams cycle by cycle against a model of the shift registers separates errors in the decrement rounding, the comparison strictness, the step length and the setup latency. Runs launched on the done cycle, a start request injected mid-run, and inputs changed after launch show whether a new run is accepted at the right moment and whether the run values are latched only once.

// File: rtl/fps_pkg.sv
// Package: shared types for the flip-pulse scheduler.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fps_pkg;
    // Run phases of the scheduler.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_RUN  = 2'd2,
        ST_TAIL = 2'd3
    } fps_state_t;
endpackage

// File: rtl/fps_lfsr.sv
// Module: Galois shift-register random word source for one pulse stream.
// Assumes: TAPS describes a maximal-length polynomial and SEED is nonzero.
module fps_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] value
);
    // Reseed on load, shift right with feedback when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            value <= SEED;
        end else if (adv) begin
            value <= value[0] ? ((value >> 1) ^ TAPS) : (value >> 1);
        end
    end
endmodule

// File: rtl/fps_divider.sv
// Module: restoring serial divider, one quotient bit per enabled cycle.
// Assumes: divisor is held stable for DW enabled cycles after load.
module fps_divider #(
    parameter int DW = 16,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [DW-1:0] quo,
    output logic [VW-1:0] rem
);
    logic [DW-1:0] dvd_q;
    logic [VW:0]   trial;

    // Partial remainder with the next dividend bit shifted in.
    always_comb begin
        trial = {rem, dvd_q[DW-1]};
    end

    // One restoring division step per shift cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            quo   <= '0;
            rem   <= '0;
        end else if (load) begin
            dvd_q <= dividend;
            quo   <= '0;
            rem   <= '0;
        end else if (shift) begin
            dvd_q <= dvd_q << 1;
            if (trial >= {1'b0, divisor}) begin
                rem <= VW'(trial - {1'b0, divisor});
                quo <= {quo[DW-2:0], 1'b1};
            end else begin
                rem <= trial[VW-1:0];
                quo <= {quo[DW-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/fps_rate_track.sv
// Module: mark-rate register with exact fractional per-step decrement.
// Assumes: qstep and rstep are the quotient and remainder of the total drop
// divided by nsteps, so nsteps ticks remove the total drop exactly.
module fps_rate_track #(
    parameter int RW = 16,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] load_val,
    input  logic          tick,
    input  logic          clear,
    input  logic [RW-1:0] qstep,
    input  logic [VW-1:0] rstep,
    input  logic [VW-1:0] nsteps,
    output logic [RW-1:0] rate
);
    localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};

    logic [VW-1:0] acc_q;
    logic [VW:0]   sum;

    // Remainder accumulator plus this step's remainder share.
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, rstep};
    end

    // Load, decrement per step with carry from the accumulator, or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate  <= '0;
            acc_q <= '0;
        end else if (load) begin
            rate  <= load_val;
            acc_q <= '0;
        end else if (clear) begin
            rate  <= '0;
        end else if (tick) begin
            if (sum >= {1'b0, nsteps}) begin
                acc_q <= VW'(sum - {1'b0, nsteps});
                rate  <= rate - qstep - ONE;
            end else begin
                acc_q <= sum[VW-1:0];
                rate  <= rate - qstep;
            end
        end
    end
endmodule

// File: rtl/flip_pulse_sched.sv
// Module: top of the flip-pulse scheduler. Sequences setup, the descending
// schedule and the zero-rate settling period, and drives two pulse streams.
// Assumes: RATE_W-bit random words are compared against a RATE_W-bit rate.
module flip_pulse_sched #(
    parameter int                RATE_W     = 16,
    parameter int                STEP_W     = 16,
    parameter int                SUBSTEPS   = 3,
    parameter int                TAIL_STEPS = 1000,
    parameter logic [RATE_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [RATE_W-1:0] SEED_A     = 16'hACE1,
    parameter logic [RATE_W-1:0] SEED_B     = 16'h1D2B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STEP_W-1:0] steps_n,
    input  logic [RATE_W-1:0] rate_init,
    input  logic [RATE_W-1:0] rate_final,
    output logic              pulse_a,
    output logic              pulse_b,
    output logic              busy,
    output logic              done
);
    import fps_pkg::*;

    localparam int SUB_W  = $clog2(SUBSTEPS + 1);
    localparam int DIV_W  = $clog2(RATE_W + 1);
    localparam int TAIL_W = $clog2(TAIL_STEPS + 1);
    localparam int NSTR   = 2;

    fps_state_t        state_q;
    logic [STEP_W-1:0] n_q;
    logic [DIV_W-1:0]  div_cnt;
    logic [SUB_W-1:0]  sub_cnt;
    logic [STEP_W-1:0] step_cnt;
    logic [TAIL_W-1:0] tail_cnt;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] qstep;
    logic [STEP_W-1:0] rstep;
    logic [RATE_W-1:0] drop_in;
    logic [RATE_W-1:0] fin_eff;
    logic [RATE_W-1:0] first_rate;
    logic [NSTR-1:0]   cmp_hit;
    logic [NSTR-1:0]   pulse_q;
    logic              accept;
    logic              active;
    logic              sub_last;
    logic              sched_end;
    logic              tail_end;

    // Launch and phase decode.
    always_comb begin
        accept     = (state_q == ST_IDLE) && start;
        active     = (state_q == ST_RUN) || (state_q == ST_TAIL);
        sub_last   = (sub_cnt == SUB_W'(SUBSTEPS - 1));
        sched_end  = (state_q == ST_RUN) && sub_last && (step_cnt == n_q);
        tail_end   = (state_q == ST_TAIL) && sub_last &&
                     (tail_cnt == TAIL_W'(TAIL_STEPS - 1));
        fin_eff    = (rate_final > rate_init) ? rate_init : rate_final;
        drop_in    = rate_init - fin_eff;
        first_rate = (steps_n == '0) ? fin_eff : rate_init;
    end

    // Phase sequencer with setup, step and settling counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            n_q      <= '0;
            div_cnt  <= '0;
            sub_cnt  <= '0;
            step_cnt <= '0;
            tail_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= tail_end;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_DIV;
                    n_q     <= steps_n;
                    div_cnt <= '0;
                end
                ST_DIV: begin
                    div_cnt <= div_cnt + DIV_W'(1);
                    if (div_cnt == DIV_W'(RATE_W - 1)) begin
                        state_q  <= ST_RUN;
                        sub_cnt  <= '0;
                        step_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    sub_cnt <= sub_last ? '0 : sub_cnt + SUB_W'(1);
                    if (sched_end) begin
                        state_q  <= ST_TAIL;
                        tail_cnt <= '0;
                    end else if (sub_last) begin
                        step_cnt <= step_cnt + STEP_W'(1);
                    end
                end
                default: begin
                    sub_cnt <= sub_last ? '0 : sub_cnt + SUB_W'(1);
                    if (tail_end) begin
                        state_q <= ST_IDLE;
                    end else if (sub_last) begin
                        tail_cnt <= tail_cnt + TAIL_W'(1);
                    end
                end
            endcase
        end
    end

    fps_divider #(.DW(RATE_W), .VW(STEP_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (state_q == ST_DIV),
        .dividend (drop_in),
        .divisor  (n_q),
        .quo      (qstep),
        .rem      (rstep)
    );

    fps_rate_track #(.RW(RATE_W), .VW(STEP_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (first_rate),
        .tick     ((state_q == ST_RUN) && sub_last && !sched_end),
        .clear    (sched_end),
        .qstep    (qstep),
        .rstep    (rstep),
        .nsteps   (n_q),
        .rate     (rate_q)
    );

    // One random source and comparator per stream.
    for (genvar g = 0; g < NSTR; g++) begin : g_stream
        logic [RATE_W-1:0] rnd;
        fps_lfsr #(
            .W    (RATE_W),
            .TAPS (LFSR_TAPS),
            .SEED ((g == 0) ? SEED_A : SEED_B)
        ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (accept),
            .adv   (active),
            .value (rnd)
        );
        assign cmp_hit[g] = (rnd < rate_q);
    end

    // Registered pulses, forced low outside the active phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= active ? cmp_hit : '0;
        end
    end

    assign pulse_a = pulse_q[0];
    assign pulse_b = pulse_q[1];
    assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/fps_checker.sv
// Module: protocol and schedule properties of the flip-pulse scheduler,
// attached to the top through bind.
// Assumes: reset is held low for at least one clock at power-up.
module fps_checker #(
    parameter int RATE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               pulse_a,
    input logic               pulse_b,
    input logic [RATE_W-1:0]  rate_cur,
    input fps_pkg::fps_state_t state_cur
);
    // R10: done lasts a single cycle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy is already low while done is shown.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: a start request during a run does not end or restart it early.
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R6: within a run the mark rate never rises.
    p_rate_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (rate_cur <= $past(rate_cur)));

    // R9: pulses are quiet when idle.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pulse_a && !pulse_b));

    // R9: every compare made during settling yields a low pulse.
    p_tail_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_cur) == fps_pkg::ST_TAIL) |-> (!pulse_a && !pulse_b));
endmodule

bind flip_pulse_sched fps_checker #(.RATE_W(RATE_W)) u_fps_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pulse_a   (pulse_a),
    .pulse_b   (pulse_b),
    .rate_cur  (rate_q),
    .state_cur (state_q)
);

// File: tb/tb_flip_pulse_sched.sv
// Bench: walks a vector table of schedules, comparing both pulse streams
// cycle by cycle to a model built from the requirements, then runs
// directed reset and mid-run tests.
module tb_flip_pulse_sched;
    localparam int TAIL = 1000;
    localparam int SUB  = 3;
    localparam int NV   = 6;

    // Vector table: steps, initial rate, final rate, mid-run poke, tag.
    localparam int    V_N   [NV] = '{4, 1, 7, 0, 3, 5};
    localparam int    V_I   [NV] = '{'hC000, 'hFFFF, 'h1000, 'h4000, 0, 'h8000};
    localparam int    V_F   [NV] = '{'h028F, 0, 'h8000, 'h2000, 0, 'h8000};
    localparam bit    V_POKE[NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam string V_TAG [NV] = '{"R6", "R6", "R7", "R8", "R4", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] steps_n = '0;
    logic [15:0] rate_init = '0;
    logic [15:0] rate_final = '0;
    logic        pulse_a, pulse_b, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    flip_pulse_sched dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .steps_n    (steps_n),
        .rate_init  (rate_init),
        .rate_final (rate_final),
        .pulse_a    (pulse_a),
        .pulse_b    (pulse_b),
        .busy       (busy),
        .done       (done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 model of the random source.
    function automatic logic [15:0] lf_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    // R6/R7/R8 model of the mark rate at step k.
    function automatic longint exp_rate(input longint k, input longint n,
                                        input longint pi, input longint pf);
        longint fe;
        fe = (pf > pi) ? pi : pf;
        if (n == 0) return fe;
        return pi - (k * (pi - fe)) / n;
    endfunction

    // Runs one schedule; entered and left at a falling edge.
    task automatic run_vec(input int n, input int pi, input int pf,
                           input bit poke, input string tag);
        logic [15:0] ra, rb;
        int total, sched, bad_a, bad_b, bad_tail, bad_ctl;
        ra = 16'hACE1;
        rb = 16'h1D2B;
        sched = SUB * (n + 1);
        total = sched + SUB * TAIL;
        bad_a = 0; bad_b = 0; bad_tail = 0; bad_ctl = 0;
        start = 1'b1; steps_n = 16'(n); rate_init = 16'(pi); rate_final = 16'(pf);
        @(posedge clk);
        @(negedge clk);
        // R2: inputs are latched, so scramble them after launch.
        start = 1'b0; steps_n = 16'h0009; rate_init = 16'h1234; rate_final = 16'hFFF0;
        chk(busy == 1'b1 && done == 1'b0, "R2", "busy after start", busy, 1);
        repeat (16) @(posedge clk);
        for (int j = 0; j < total; j++) begin
            logic ea, eb;
            @(posedge clk);
            @(negedge clk);
            if (j < sched) begin
                ea = (longint'(ra) < exp_rate(j / SUB, n, pi, pf));
                eb = (longint'(rb) < exp_rate(j / SUB, n, pi, pf));
                if (pulse_a !== ea) bad_a++;
                if (pulse_b !== eb) bad_b++;
            end else if (pulse_a !== 1'b0 || pulse_b !== 1'b0) begin
                bad_tail++;
            end
            ra = lf_next(ra);
            rb = lf_next(rb);
            if (j == total - 1) begin
                if (done !== 1'b1 || busy !== 1'b0) bad_ctl++;
            end else if (done !== 1'b0 || busy !== 1'b1) begin
                bad_ctl++;
            end
            // R2: a start request mid-run must be ignored.
            start = (poke && j == 4) ? 1'b1 : 1'b0;
        end
        chk(bad_a == 0, tag, "stream A mismatches (R3 R4 R5)", bad_a, 0);
        chk(bad_b == 0, tag, "stream B mismatches (R3 R4 R5)", bad_b, 0);
        chk(bad_tail == 0, "R9", "pulses during settling", bad_tail, 0);
        chk(bad_ctl == 0, "R10", "busy/done timing errors", bad_ctl, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs during reset.
        chk(!busy && !done && !pulse_a && !pulse_b, "R1", "outputs in reset",
            {busy, done, pulse_a, pulse_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pulse_a && !pulse_b, "R1", "outputs after reset",
            {busy, done, pulse_a, pulse_b}, 0);

        // Table walk; each next run starts in the done cycle of the last (R10).
        for (int v = 0; v < NV; v++) begin
            run_vec(V_N[v], V_I[v], V_F[v], V_POKE[v], V_TAG[v]);
        end
        @(negedge clk);
        chk(!done && !busy, "R10", "done drops after one cycle", done, 0);

        // R1: reset asserted mid-run clears everything.
        start = 1'b1; steps_n = 16'd50; rate_init = 16'hFFFF; rate_final = 16'h8000;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R2", "busy mid-run before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pulse_a && !pulse_b, "R1", "outputs after mid-run reset",
            {busy, done, pulse_a, pulse_b}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy && !pulse_a && !pulse_b, "R9", "idle stays quiet",
            {busy, pulse_a, pulse_b}, 0);

        // R5/R3: a fresh run after reset reseeds and starts from the seeds.
        run_vec(2, 'hFFFF, 'h0100, 1'b0, "R5");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule